// File: doc/BRIEF.md
# Frame-Indexed Translation Engine with Hashed Chains

This block translates a process identifier and a virtual address into a physical address. It keeps a single table that is shared by all processes and holds exactly one entry per physical frame; the index of an entry is the frame number that entry describes. A lookup cannot index that table by page number. The block therefore mixes the process identifier and the page number into a bucket number. A small anchor table gives the first frame of that bucket's chain. The block then walks the chain, whose links are stored inside the frame entries, until it finds the mapping or reaches the end of the chain.

Commands are taken one at a time over a valid/ready handshake. A command is either a lookup or an insert. An insert installs a mapping for a chosen frame and places it at the head of its bucket chain. Every command ends with a one-cycle response pulse. The pulse carries a status, the physical address, the entry's control byte and the number of chain entries visited. Both tables are on-chip registers, and a synchronous active-high reset clears them.

Top module: `rpt_xlate`

## Requirements
- R1: After reset every frame entry is invalid and every bucket anchor holds the end marker 0xFFFFFFFF, so any lookup ends with status FAULT (1) and depth 0. While no command is in flight, cmd_ready is high and rsp_valid is low.
- R2: The bucket is formed from a 64-bit key with the process id in bits 63:48 and page-number bits 47:0 below it. The key is XORed with HASH_SEED, then put through three xor-shift-right-33 steps. The first two of these are each followed by a multiply, by 0xFF51AFD7ED558CCD and then by 0xC4CEB9FE1A85EC53. The bucket is the low log2(NUM_BUCKETS) bits of the result. Page-number bits above 47 do not affect the bucket.
- R3: An insert whose frame number is NUM_FRAMES or more completes with status REJECT (2), and the tables are left unchanged.
- R4: An insert aimed at a frame whose entry is already valid completes with status REJECT. The existing mapping of that frame stays intact, and the refused key still faults.
- R5: An accepted insert completes with status OK (0) and rsp_ctrl equal to the supplied control byte with bit 0 (valid) forced to 1. The entry keeps the process id, the page number (address bits 63:12) and that control byte.
- R6: A lookup that matches returns status OK and rsp_paddr equal to the frame number shifted left by 12, ORed with address bits 11:0.
- R7: An entry matches only if its valid bit is set and both its process id and its full 52-bit page number equal the request. The same page number under another process id faults.
- R8: A new insert becomes the head of its bucket chain. A matching lookup reports as rsp_depth the 1-based position of the entry from the head, so the entry inserted last in a bucket reports depth 1.
- R9: A lookup that reaches the end marker without a match reports FAULT, with rsp_depth equal to the number of entries chained in its bucket.
- R10: A matching lookup returns the entry's control byte as it was before the lookup, then sets bit 6 (accessed) in the stored entry. A repeated lookup therefore returns bit 6 set.
- R11: A command is accepted only while cmd_ready is high. cmd_ready goes low in the cycle after an acceptance and stays low until the single rsp_valid pulse for that command. Status code 3 (LIMIT) marks a walk that exceeds NUM_FRAMES visits or meets a link outside the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 1 | 0 = lookup, 1 = insert |
| cmd_pid | input | 16 | Process identifier |
| cmd_vaddr | input | 64 | Virtual address; bits 63:12 give the page number |
| cmd_frame | input | 32 | Frame number for an insert |
| cmd_ctrl | input | 8 | Control byte for an insert |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 OK, 1 FAULT, 2 REJECT, 3 LIMIT |
| rsp_paddr | output | log2(NUM_FRAMES)+12 | Physical address of a matching lookup |
| rsp_ctrl | output | 8 | Control byte of the matched or written entry |
| rsp_depth | output | log2(NUM_FRAMES+1) | Chain entries visited |

## Verification
A broken link or a wrong anchor does not show up at the insert that caused it. It appears at the first lookup that walks that bucket, either as a wrong rsp_depth or as a FAULT where a match is expected. For that reason, every installed mapping is looked up and its depth is compared against an insertion-order model of each bucket. A corrupted control byte appears at the next lookup of that frame. A missed accessed-bit update appears only at the second lookup of the same key. A wrong hash bit alters the collision pattern, and therefore the depths, across the full sweep of sixteen frames.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int PID_W  = 16;
    localparam int VPN_W  = 52;
    localparam int CTRL_W = 8;
    localparam int LINK_W = 32;
    localparam int OFS_W  = 12;
    localparam int VA_W   = 64;
    localparam int KEY_VPN_W = 48;

    localparam logic [LINK_W-1:0] LINK_END = '1;

    localparam int CB_VALID    = 0;
    localparam int CB_READ     = 1;
    localparam int CB_WRITE    = 2;
    localparam int CB_EXEC     = 3;
    localparam int CB_USER     = 4;
    localparam int CB_DIRTY    = 5;
    localparam int CB_ACCESSED = 6;
    localparam int CB_WIRED    = 7;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_FAULT  = 2'd1,
        ST_REJECT = 2'd2,
        ST_LIMIT  = 2'd3
    } status_e;

    typedef enum logic {
        OP_LOOKUP = 1'b0,
        OP_INSERT = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_HEAD = 2'd1,
        FS_WALK = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [CTRL_W-1:0] ctrl;
        logic [LINK_W-1:0] link;
    } frame_ent_t;

    localparam frame_ent_t ENT_EMPTY = '{pid: '0, vpn: '0, ctrl: '0, link: LINK_END};

    // Build the 64-bit hash key: pid on top, low page-number bits below.
    function automatic logic [63:0] make_key(input logic [PID_W-1:0] pid,
                                             input logic [VPN_W-1:0] vpn);
        return {pid, vpn[KEY_VPN_W-1:0]};
    endfunction

    // Two-multiply avalanche mixer.
    function automatic logic [63:0] mix64(input logic [63:0] x);
        logic [63:0] h;
        h = x;
        h = h ^ (h >> 33);
        h = h * 64'hFF51AFD7ED558CCD;
        h = h ^ (h >> 33);
        h = h * 64'hC4CEB9FE1A85EC53;
        h = h ^ (h >> 33);
        return h;
    endfunction

endpackage

// File: rtl/rpt_hash.sv
module rpt_hash
    import rpt_pkg::*;
#(
    parameter logic [63:0] SEED  = 64'h0,
    parameter int          BKT_W = 3
) (
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    output logic [BKT_W-1:0] bucket
);

    // Bucket count is a power of two: the modulo is a mask of the low bits.
    assign bucket = BKT_W'(mix64(make_key(pid, vpn) ^ SEED));

endmodule

// File: rtl/rpt_anchor_tbl.sv
module rpt_anchor_tbl
    import rpt_pkg::*;
#(
    parameter int NUM_BUCKETS = 8,
    parameter int BKT_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BKT_W-1:0]  rd_idx,
    output logic [LINK_W-1:0] rd_link,
    input  logic              wr_en,
    input  logic [BKT_W-1:0]  wr_idx,
    input  logic [LINK_W-1:0] wr_link
);

    logic [LINK_W-1:0] head_q [NUM_BUCKETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BUCKETS; b++) head_q[b] <= LINK_END;
        end else if (wr_en) begin
            head_q[wr_idx] <= wr_link;
        end
    end

    assign rd_link = head_q[rd_idx];

    // R1
    anchor_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_link == LINK_END));

endmodule

// File: rtl/rpt_frame_tbl.sv
module rpt_frame_tbl
    import rpt_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int FRM_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FRM_W-1:0] rd_idx,
    output frame_ent_t       rd_ent,
    input  logic             wr_en,
    input  logic [FRM_W-1:0] wr_idx,
    input  frame_ent_t       wr_ent
);

    frame_ent_t ent_q [NUM_FRAMES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NUM_FRAMES; f++) ent_q[f] <= ENT_EMPTY;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = ent_q[rd_idx];

    // R5
    write_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_ent.ctrl[CB_VALID]);

endmodule

// File: rtl/rpt_xlate.sv
module rpt_xlate
    import rpt_pkg::*;
#(
    parameter int          NUM_FRAMES  = 16,
    parameter int          NUM_BUCKETS = 8,
    parameter logic [63:0] HASH_SEED   = 64'h5A5A_0123_89AB_CDEF,
    localparam int         FRM_W       = $clog2(NUM_FRAMES),
    localparam int         PA_W        = FRM_W + 12,
    localparam int         DEPTH_W     = $clog2(NUM_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_op,
    input  logic [15:0]        cmd_pid,
    input  logic [63:0]        cmd_vaddr,
    input  logic [31:0]        cmd_frame,
    input  logic [7:0]         cmd_ctrl,
    output logic               rsp_valid,
    output logic [1:0]         rsp_status,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [7:0]         rsp_ctrl,
    output logic [DEPTH_W-1:0] rsp_depth
);

    localparam int BKT_W = $clog2(NUM_BUCKETS);
    localparam logic [LINK_W-1:0] FRAME_LIM = LINK_W'(NUM_FRAMES);
    localparam logic [DEPTH_W-1:0] DEPTH_LIM = DEPTH_W'(NUM_FRAMES);

    fsm_e               st_q;
    op_e                req_op;
    logic [PID_W-1:0]   req_pid;
    logic [VPN_W-1:0]   req_vpn;
    logic [OFS_W-1:0]   req_ofs;
    logic [LINK_W-1:0]  req_frame;
    logic [CTRL_W-1:0]  req_ctrl;
    logic [LINK_W-1:0]  cur_q;
    logic [DEPTH_W-1:0] depth_q;

    logic [BKT_W-1:0]   bucket;
    logic [LINK_W-1:0]  anchor_rd;
    logic               anchor_we;
    logic [FRM_W-1:0]   ent_rd_idx;
    frame_ent_t         ent_rd;
    logic               ent_we;
    logic [FRM_W-1:0]   ent_wr_idx;
    frame_ent_t         ent_wr;

    logic               hit;
    logic               ins_range_bad;
    logic [DEPTH_W-1:0] depth_nx;

    rpt_hash #(.SEED(HASH_SEED), .BKT_W(BKT_W)) u_hash (
        .pid    (req_pid),
        .vpn    (req_vpn),
        .bucket (bucket)
    );

    rpt_anchor_tbl #(.NUM_BUCKETS(NUM_BUCKETS), .BKT_W(BKT_W)) u_anchor (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (bucket),
        .rd_link (anchor_rd),
        .wr_en   (anchor_we),
        .wr_idx  (bucket),
        .wr_link (req_frame)
    );

    rpt_frame_tbl #(.NUM_FRAMES(NUM_FRAMES), .FRM_W(FRM_W)) u_frames (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ent_rd_idx),
        .rd_ent (ent_rd),
        .wr_en  (ent_we),
        .wr_idx (ent_wr_idx),
        .wr_ent (ent_wr)
    );

    assign cmd_ready     = (st_q == FS_IDLE);
    assign ins_range_bad = (req_frame >= FRAME_LIM);
    assign ent_rd_idx    = (st_q == FS_WALK) ? cur_q[FRM_W-1:0] : req_frame[FRM_W-1:0];
    assign depth_nx      = depth_q + 1'b1;
    assign hit           = ent_rd.ctrl[CB_VALID] && (ent_rd.pid == req_pid)
                           && (ent_rd.vpn == req_vpn);

    // Table write control: insert at head, or accessed-bit update on a hit.
    always_comb begin
        anchor_we  = 1'b0;
        ent_we     = 1'b0;
        ent_wr_idx = ent_rd_idx;
        ent_wr     = ent_rd;
        if (st_q == FS_HEAD && req_op == OP_INSERT && !ins_range_bad
            && !ent_rd.ctrl[CB_VALID]) begin
            anchor_we = 1'b1;
            ent_we    = 1'b1;
            ent_wr    = '{pid: req_pid, vpn: req_vpn,
                          ctrl: req_ctrl | CTRL_W'(1 << CB_VALID), link: anchor_rd};
        end else if (st_q == FS_WALK && cur_q != LINK_END && depth_q != DEPTH_LIM
                     && cur_q < FRAME_LIM && hit) begin
            ent_we = 1'b1;
            ent_wr.ctrl[CB_ACCESSED] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FS_IDLE;
            req_op     <= OP_LOOKUP;
            req_pid    <= '0;
            req_vpn    <= '0;
            req_ofs    <= '0;
            req_frame  <= '0;
            req_ctrl   <= '0;
            cur_q      <= LINK_END;
            depth_q    <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_paddr  <= '0;
            rsp_ctrl   <= '0;
            rsp_depth  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st_q)
                FS_IDLE: begin
                    if (cmd_valid) begin
                        req_op    <= op_e'(cmd_op);
                        req_pid   <= cmd_pid;
                        req_vpn   <= cmd_vaddr[VA_W-1:OFS_W];
                        req_ofs   <= cmd_vaddr[OFS_W-1:0];
                        req_frame <= cmd_frame;
                        req_ctrl  <= cmd_ctrl;
                        st_q      <= FS_HEAD;
                    end
                end
                FS_HEAD: begin
                    depth_q <= '0;
                    if (req_op == OP_INSERT) begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= '0;
                        rsp_depth <= '0;
                        st_q      <= FS_IDLE;
                        if (ins_range_bad || ent_rd.ctrl[CB_VALID]) begin
                            rsp_status <= ST_REJECT;
                            rsp_ctrl   <= '0;
                        end else begin
                            rsp_status <= ST_OK;
                            rsp_ctrl   <= req_ctrl | CTRL_W'(1 << CB_VALID);
                        end
                    end else begin
                        cur_q <= anchor_rd;
                        st_q  <= FS_WALK;
                    end
                end
                FS_WALK: begin
                    if (cur_q == LINK_END) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_FAULT;
                        rsp_paddr  <= '0;
                        rsp_ctrl   <= '0;
                        rsp_depth  <= depth_q;
                        st_q       <= FS_IDLE;
                    end else if (depth_q == DEPTH_LIM || cur_q >= FRAME_LIM) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_LIMIT;
                        rsp_paddr  <= '0;
                        rsp_ctrl   <= '0;
                        rsp_depth  <= depth_q;
                        st_q       <= FS_IDLE;
                    end else if (hit) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_OK;
                        rsp_paddr  <= {cur_q[FRM_W-1:0], req_ofs};
                        rsp_ctrl   <= ent_rd.ctrl;
                        rsp_depth  <= depth_nx;
                        st_q       <= FS_IDLE;
                    end else begin
                        cur_q   <= ent_rd.link;
                        depth_q <= depth_nx;
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cmd_ready);

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_depth <= DEPTH_LIM));

    // R3
    reject_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_HEAD && req_op == OP_INSERT && ins_range_bad)
        |=> (rsp_valid && rsp_status == ST_REJECT));

    // R10
    hit_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_we && st_q == FS_WALK) |-> ent_wr.ctrl[CB_ACCESSED]);

endmodule

// File: tb/rpt_xlate_tb.sv
module rpt_xlate_tb;

    localparam int NF = 16;
    localparam int NB = 8;
    localparam logic [63:0] SEED = 64'h5A5A_0123_89AB_CDEF;
    localparam int PA_W = 4 + 12;
    localparam int DEPTH_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic cmd_op = 1'b0;
    logic [15:0] cmd_pid = '0;
    logic [63:0] cmd_vaddr = '0;
    logic [31:0] cmd_frame = '0;
    logic [7:0] cmd_ctrl = '0;
    logic rsp_valid;
    logic [1:0] rsp_status;
    logic [PA_W-1:0] rsp_paddr;
    logic [7:0] rsp_ctrl;
    logic [DEPTH_W-1:0] rsp_depth;

    always #5 clk = ~clk;

    rpt_xlate #(.NUM_FRAMES(NF), .NUM_BUCKETS(NB), .HASH_SEED(SEED)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_pid(cmd_pid), .cmd_vaddr(cmd_vaddr),
        .cmd_frame(cmd_frame), .cmd_ctrl(cmd_ctrl), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .rsp_ctrl(rsp_ctrl),
        .rsp_depth(rsp_depth)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0]  got_st;
    logic [63:0] got_pa;
    logic [7:0]  got_ctrl;
    logic [63:0] got_depth;

    // bench model
    bit          m_valid [NF];
    logic [15:0] m_pid   [NF];
    logic [51:0] m_vpn   [NF];
    logic [7:0]  m_ctrl  [NF];
    int          m_seq   [NF];
    int          m_bkt   [NF];

    function automatic int bench_bucket(input logic [15:0] pid, input logic [51:0] vpn);
        logic [63:0] k;
        k = {pid, vpn[47:0]} ^ SEED;
        k = k ^ (k >> 33);
        k = k * 64'hFF51AFD7ED558CCD;
        k = k ^ (k >> 33);
        k = k * 64'hC4CEB9FE1A85EC53;
        k = k ^ (k >> 33);
        return int'(k % NB);
    endfunction

    function automatic int chain_len(input int b);
        int c = 0;
        for (int g = 0; g < NF; g++) if (m_valid[g] && m_bkt[g] == b) c++;
        return c;
    endfunction

    function automatic int pos_of(input int f);
        int c = 0;
        for (int g = 0; g < NF; g++)
            if (m_valid[g] && m_bkt[g] == m_bkt[f] && m_seq[g] >= m_seq[f]) c++;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic op, input logic [15:0] pid, input logic [63:0] va,
                           input logic [31:0] frame, input logic [7:0] ctrl);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pid = pid; cmd_vaddr = va;
        cmd_frame = frame; cmd_ctrl = ctrl;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid && n < 64) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) check(1'b0, "R11 response timeout", 64'(n), 64'd0);
        got_st = rsp_status; got_pa = 64'(rsp_paddr); got_ctrl = rsp_ctrl;
        got_depth = 64'(rsp_depth);
    endtask

    task automatic lookup_hit(input int f, input logic [11:0] ofs, input bit seen, input string req);
        run_cmd(1'b0, m_pid[f], {m_vpn[f], ofs}, 32'd0, 8'd0);
        check(got_st == 2'd0, {req, " status"}, 64'(got_st), 64'd0);
        check(got_pa == ((64'(f) << 12) | 64'(ofs)), "R6 paddr", got_pa,
              (64'(f) << 12) | 64'(ofs));
        check(got_depth == 64'(pos_of(f)), "R8 depth", got_depth, 64'(pos_of(f)));
        check(got_ctrl == (m_ctrl[f] | (seen ? 8'h40 : 8'h00)), "R10 ctrl", 64'(got_ctrl),
              64'(m_ctrl[f] | (seen ? 8'h40 : 8'h00)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < NF; f++) m_valid[f] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 idle state after reset
        check(cmd_ready == 1'b1, "R1 ready after reset", 64'(cmd_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        // R1 empty table faults with depth 0
        for (int i = 0; i < 4; i++) begin
            run_cmd(1'b0, 16'(i * 3 + 1), 64'(i) << 20, 32'd0, 8'd0);
            check(got_st == 2'd1, "R1 empty lookup status", 64'(got_st), 64'd1);
            check(got_depth == 0, "R1 empty lookup depth", got_depth, 64'd0);
        end
        // R3 out-of-range frames
        run_cmd(1'b1, 16'h0010, 64'h5000, 32'(NF), 8'h02);
        check(got_st == 2'd2, "R3 reject frame NF", 64'(got_st), 64'd2);
        run_cmd(1'b1, 16'h0010, 64'h5000, 32'hFFFF_FFF0, 8'h02);
        check(got_st == 2'd2, "R3 reject large frame", 64'(got_st), 64'd2);
        run_cmd(1'b0, 16'h0010, 64'h5000, 32'd0, 8'd0);
        check(got_st == 2'd1, "R3 rejected key absent", 64'(got_st), 64'd1);
        // R5 fill every frame in a scrambled order
        for (int i = 0; i < NF; i++) begin
            int f;
            logic [7:0] c;
            f = (i * 5 + 3) % NF;
            c = 8'((f % 16) << 1) | ((f % 2 == 1) ? 8'h80 : 8'h00);
            m_pid[f] = 16'h0100 + 16'(f % 3);
            m_vpn[f] = 52'h1000 + 52'(f * 7);
            m_ctrl[f] = c | 8'h01;
            m_seq[f] = i;
            m_bkt[f] = bench_bucket(m_pid[f], m_vpn[f]);
            run_cmd(1'b1, m_pid[f], {m_vpn[f], 12'h000}, 32'(f), c);
            check(got_st == 2'd0, "R5 insert status", 64'(got_st), 64'd0);
            check(got_ctrl == m_ctrl[f], "R5 insert ctrl", 64'(got_ctrl), 64'(m_ctrl[f]));
            m_valid[f] = 1'b1;
        end
        // R4 occupied frame refused, new key absent
        run_cmd(1'b1, 16'h0222, {52'h9_9999, 12'h0}, 32'd5, 8'h06);
        check(got_st == 2'd2, "R4 reject occupied", 64'(got_st), 64'd2);
        run_cmd(1'b0, 16'h0222, {52'h9_9999, 12'h0}, 32'd0, 8'd0);
        check(got_st == 2'd1, "R4 refused key faults", 64'(got_st), 64'd1);
        check(got_depth == 64'(chain_len(bench_bucket(16'h0222, 52'h9_9999))),
              "R9 refused key depth", got_depth,
              64'(chain_len(bench_bucket(16'h0222, 52'h9_9999))));
        // R6 R8 R10 first and second lookups of every frame
        for (int f = 0; f < NF; f++) lookup_hit(f, 12'(f * 12'h111), 1'b0, "R6 first");
        for (int f = 0; f < NF; f++) lookup_hit(f, 12'hFFF - 12'(f), 1'b1, "R10 second");
        // R7 R9 misses: other pid, neighbouring page, high page bits
        for (int f = 0; f < NF; f++) begin
            int b;
            b = bench_bucket(m_pid[f] + 16'd50, m_vpn[f]);
            run_cmd(1'b0, m_pid[f] + 16'd50, {m_vpn[f], 12'h0}, 32'd0, 8'd0);
            check(got_st == 2'd1, "R7 other pid faults", 64'(got_st), 64'd1);
            check(got_depth == 64'(chain_len(b)), "R9 miss depth", got_depth, 64'(chain_len(b)));
            b = bench_bucket(m_pid[f], m_vpn[f] + 52'd1);
            run_cmd(1'b0, m_pid[f], {m_vpn[f] + 52'd1, 12'h0}, 32'd0, 8'd0);
            check(got_st == 2'd1, "R7 other page faults", 64'(got_st), 64'd1);
            check(got_depth == 64'(chain_len(b)), "R9 miss depth page", got_depth,
                  64'(chain_len(b)));
            // R2 bits above 47 leave the bucket unchanged: full chain walked
            run_cmd(1'b0, m_pid[f], {m_vpn[f] ^ (52'h1 << 50), 12'h0}, 32'd0, 8'd0);
            check(got_st == 2'd1, "R2 high-bit key faults", 64'(got_st), 64'd1);
            check(got_depth == 64'(chain_len(m_bkt[f])), "R2 high-bit same bucket", got_depth,
                  64'(chain_len(m_bkt[f])));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule